// File: doc/BRIEF.md
# Discrete Pattern-Bank Cartridge Mapper

This block sits between a game console's two buses and the memories of a simple cartridge. On the CPU side, any write into the upper half of the 64 KiB address space loads a small bank latch. The 32 KiB program ROM there is not banked and is outside this block. Optionally, the latched byte is the write data ANDed with the program ROM byte that the cartridge drives onto the same bus. The block also decodes a 2 KiB work RAM that repeats across the 8 KiB range just below the program ROM.

On the PPU side, the latch chooses which 8 KiB pattern bank appears in the pattern window. A run-time mode input picks how the latch is used. It can select one of four banks, select one of sixteen banks, or act as a two-bit chip-select key for a protected 8 KiB part. When the key does not match, the pattern ROM stays silent and the block returns open-bus data. The nametable arrangement is a static strap that register writes never touch.

Top module: `chr_bank_mapper`

## Requirements
- R1: After reset the latch is zero, so in mode 00 `chr_addr` equals `ppu_addr[12:0]` with zero bank bits, and `aux_out` is 0.
- R2: A CPU write loads the latch only when `cpu_addr[15]` is 1. A write with `cpu_addr[15]` at 0 leaves the latch, and so the bank bits and `aux_out`, unchanged.
- R3: With parameter BUS_CONFLICT=1 the latch takes `cpu_wdata & prg_rdata`. With BUS_CONFLICT=0 it takes `cpu_wdata`.
- R4: In mode 00 (four banks), `chr_addr[14:13]` equals latch bits 1:0, `chr_addr[16:15]` is 0, and `chr_addr[12:0]` equals `ppu_addr[12:0]`.
- R5: In mode 01 (sixteen banks), `chr_addr[16:13]` equals latch bits 3:0.
- R6: In protected mode (`cfg_mode[1]`=1) with KEY_KNOWN=1, the pattern ROM is enabled only while latch bits 1:0 equal PROT_KEY. Other latch bits do not matter, and the bank bits of `chr_addr` are 0.
- R7: While the pattern ROM is disabled, `chr_drive` and `chr_ce` are 0 and `chr_dout` equals `ppu_addr[7:0]`. While it is enabled inside the window, `chr_drive` and `chr_ce` are 1 and `chr_dout` equals `chr_rdata`.
- R8: In protected mode with KEY_KNOWN=0, the pattern ROM is disabled during the first two PPU data-port reads after reset. Each read is one cycle with `ppu_dport_rd` at 1. From the third read on, the ROM is enabled whatever the latch holds.
- R9: `aux_out` equals latch bits 5:4 and has no effect on `chr_addr`.
- R10: With `cfg_mirror_v`=0, `ciram_a10` equals `ppu_addr[10]`. With `cfg_mirror_v`=1, it equals `ppu_addr[11]`. Latch writes never change it.
- R11: `wram_sel` is 1 exactly when `cpu_addr[15:13]` is 3'b011 (and WRAM_EN=1), and `wram_addr` equals `cpu_addr[10:0]`.
- R12: For a PPU address with bit 13 set (outside the pattern window), `chr_ce` and `chr_drive` are 0 and `chr_dout` equals `ppu_addr[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | 00 four banks, 01 sixteen banks, 1x protected |
| cfg_mirror_v | input | 1 | Strap: 1 for vertical nametable arrangement |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| prg_rdata | input | 8 | Program ROM byte at `cpu_addr` |
| ppu_addr | input | 14 | PPU address |
| ppu_dport_rd | input | 1 | One cycle high per PPU data-port read |
| chr_rdata | input | 8 | Byte from the pattern ROM |
| chr_addr | output | 17 | Pattern ROM address |
| chr_ce | output | 1 | Pattern ROM chip enable |
| chr_dout | output | 8 | Pattern data returned to the PPU |
| chr_drive | output | 1 | 1 when `chr_dout` is ROM data, 0 for open bus |
| ciram_a10 | output | 1 | Nametable RAM page select |
| aux_out | output | 2 | Latch bits 5:4 |
| wram_sel | output | 1 | Work RAM select |
| wram_addr | output | 11 | Work RAM address |

## Verification
The bench builds two copies of the block that share every input. The first copy has BUS_CONFLICT=0, KEY_KNOWN=1 and PROT_KEY=2, so the raw write data can be seen in the bank bits and a matching key and a wrong key can be compared. The second copy has BUS_CONFLICT=1 and KEY_KNOWN=0. Each write therefore shows the ANDed value next to the plain one, and the count of data-port reads after reset can be followed in protected mode.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;

  parameter int unsigned LATCH_W = 8;
  parameter int unsigned BANK_W  = 4;

  typedef enum logic [1:0] {
    MODE_FOUR    = 2'b00,
    MODE_SIXTEEN = 2'b01,
    MODE_PROT_A  = 2'b10,
    MODE_PROT_B  = 2'b11
  } map_mode_e;

  function automatic logic is_prot(input map_mode_e m);
    return m[1];
  endfunction

  // Value that lands in the latch for one CPU write.
  function automatic logic [LATCH_W-1:0] latch_value(input logic [LATCH_W-1:0] wdata,
                                                     input logic [LATCH_W-1:0] rom_byte,
                                                     input bit                 and_bus);
    return and_bus ? (wdata & rom_byte) : wdata;
  endfunction

  // Bank number placed above the 8 KiB offset.
  function automatic logic [BANK_W-1:0] bank_of(input map_mode_e m,
                                                input logic [LATCH_W-1:0] lat);
    logic [BANK_W-1:0] b;
    b = '0;
    if (m == MODE_FOUR)         b[1:0] = lat[1:0];
    else if (m == MODE_SIXTEEN) b      = lat[BANK_W-1:0];
    return b;
  endfunction

endpackage

// File: rtl/chr_bank_latch.sv
module chr_bank_latch
  import chr_map_pkg::*;
#(
  parameter bit BUS_CONFLICT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic [LATCH_W-1:0] wdata,
  input  logic [LATCH_W-1:0] rom_byte,
  output logic [LATCH_W-1:0] latch_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      latch_q <= '0;
    else if (wr_hit) latch_q <= latch_value(wdata, rom_byte, BUS_CONFLICT);
  end

  a_r3_conflict_and : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && BUS_CONFLICT) |=> (latch_q == ($past(wdata) & $past(rom_byte))));

  a_r3_plain_write : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !BUS_CONFLICT) |=> (latch_q == $past(wdata)));

endmodule

// File: rtl/chr_prot_gate.sv
module chr_prot_gate #(
  parameter bit          KEY_KNOWN     = 1'b1,
  parameter int unsigned PROT_KEY      = 0,
  parameter int unsigned STARTUP_READS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dport_rd,
  input  logic [1:0] cs_bits,
  output logic       prot_ok,
  output logic       startup_done
);

  localparam int unsigned CNT_W = $clog2(STARTUP_READS + 1);
  localparam logic [1:0]  KEY   = PROT_KEY[1:0];

  logic [CNT_W-1:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                        rd_cnt <= '0;
    else if (dport_rd && !startup_done) rd_cnt <= rd_cnt + 1'b1;
  end

  assign startup_done = (rd_cnt == CNT_W'(STARTUP_READS));

  generate
    if (KEY_KNOWN) begin : g_key
      assign prot_ok = (cs_bits == KEY);
    end else begin : g_count
      assign prot_ok = startup_done;
    end
  endgenerate

  a_r8_done_sticks : assert property (@(posedge clk) disable iff (!rst_n)
    startup_done |=> startup_done);

  a_r8_count_bound : assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= CNT_W'(STARTUP_READS));

  a_r8_one_step : assert property (@(posedge clk) disable iff (!rst_n)
    (dport_rd && !startup_done) |=> (rd_cnt == $past(rd_cnt) + 1'b1));

endmodule

// File: rtl/chr_addr_map.sv
module chr_addr_map
  import chr_map_pkg::*;
#(
  parameter int unsigned CHR_AW = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  map_mode_e          mode,
  input  logic [LATCH_W-1:0] latch_q,
  input  logic               prot_ok,
  input  logic [13:0]        ppu_addr,
  input  logic [7:0]         chr_rdata,
  output logic [CHR_AW-1:0]  chr_addr,
  output logic               chr_ce,
  output logic [7:0]         chr_dout,
  output logic               chr_drive
);

  localparam int unsigned OFS_W = 13;

  logic in_window;
  logic rom_on;

  assign in_window = !ppu_addr[13];
  assign rom_on    = !is_prot(mode) || prot_ok;
  assign chr_addr  = {bank_of(mode, latch_q), ppu_addr[OFS_W-1:0]};
  assign chr_drive = rom_on && in_window;
  assign chr_ce    = chr_drive;
  assign chr_dout  = chr_drive ? chr_rdata : ppu_addr[7:0];

  a_r7_open_bus : assert property (@(posedge clk) disable iff (!rst_n)
    (is_prot(mode) && !prot_ok) |-> (!chr_ce && chr_dout == ppu_addr[7:0]));

  a_r12_window : assert property (@(posedge clk) disable iff (!rst_n)
    ppu_addr[13] |-> (!chr_drive && !chr_ce));

  a_r6_prot_bank_zero : assert property (@(posedge clk) disable iff (!rst_n)
    is_prot(mode) |-> (chr_addr[CHR_AW-1:OFS_W] == '0));

endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
  import chr_map_pkg::*;
#(
  parameter bit          BUS_CONFLICT  = 1'b1,
  parameter bit          KEY_KNOWN     = 1'b1,
  parameter int unsigned PROT_KEY      = 0,
  parameter int unsigned STARTUP_READS = 2,
  parameter bit          WRAM_EN       = 1'b1,
  parameter int unsigned CHR_AW        = 17,
  parameter int unsigned WRAM_AW       = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_mode,
  input  logic               cfg_mirror_v,
  input  logic               cpu_wr,
  input  logic [15:0]        cpu_addr,
  input  logic [7:0]         cpu_wdata,
  input  logic [7:0]         prg_rdata,
  input  logic [13:0]        ppu_addr,
  input  logic               ppu_dport_rd,
  input  logic [7:0]         chr_rdata,
  output logic [CHR_AW-1:0]  chr_addr,
  output logic               chr_ce,
  output logic [7:0]         chr_dout,
  output logic               chr_drive,
  output logic               ciram_a10,
  output logic [1:0]         aux_out,
  output logic               wram_sel,
  output logic [WRAM_AW-1:0] wram_addr
);

  map_mode_e          mode;
  logic               wr_hit;
  logic [LATCH_W-1:0] latch_q;
  logic               prot_ok;
  logic               startup_done;
  logic               unused_bits;

  assign mode   = map_mode_e'(cfg_mode);
  assign wr_hit = cpu_wr && cpu_addr[15];

  chr_bank_latch #(.BUS_CONFLICT(BUS_CONFLICT)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit),
    .wdata(cpu_wdata), .rom_byte(prg_rdata), .latch_q(latch_q)
  );

  chr_prot_gate #(
    .KEY_KNOWN(KEY_KNOWN), .PROT_KEY(PROT_KEY), .STARTUP_READS(STARTUP_READS)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .dport_rd(ppu_dport_rd),
    .cs_bits(latch_q[1:0]), .prot_ok(prot_ok), .startup_done(startup_done)
  );

  chr_addr_map #(.CHR_AW(CHR_AW)) u_map (
    .clk(clk), .rst_n(rst_n), .mode(mode), .latch_q(latch_q),
    .prot_ok(prot_ok), .ppu_addr(ppu_addr), .chr_rdata(chr_rdata),
    .chr_addr(chr_addr), .chr_ce(chr_ce), .chr_dout(chr_dout),
    .chr_drive(chr_drive)
  );

  assign aux_out   = latch_q[5:4];
  assign ciram_a10 = cfg_mirror_v ? ppu_addr[11] : ppu_addr[10];
  assign wram_sel  = WRAM_EN && (cpu_addr[15:13] == 3'b011);
  assign wram_addr = cpu_addr[WRAM_AW-1:0];

  assign unused_bits = ^{latch_q[LATCH_W-1:6], cpu_addr[12:WRAM_AW], startup_done};

  a_r2_low_write_ignored : assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_addr[15]) |=> $stable(latch_q));

  a_r2_no_write_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> $stable(latch_q));

  a_r10_mirror_static : assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(cfg_mirror_v) && $stable(ppu_addr)) |-> $stable(ciram_a10));

  a_r11_wram_range : assert property (@(posedge clk) disable iff (!rst_n)
    wram_sel |-> (!cpu_addr[15] && cpu_addr[14] && cpu_addr[13]));

endmodule

// File: tb/chr_bank_mapper_tb.sv
module chr_bank_mapper_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic        cfg_mirror_v = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  prg_rdata = '0;
  logic [13:0] ppu_addr = '0;
  logic        ppu_dport_rd = 1'b0;
  logic [7:0]  chr_rdata = 8'hA5;

  logic [16:0] a_addr, b_addr;
  logic        a_ce, b_ce, a_drive, b_drive, a_mir, b_mir, a_wsel, b_wsel;
  logic [7:0]  a_dout, b_dout;
  logic [1:0]  a_aux, b_aux;
  logic [10:0] a_waddr, b_waddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  chr_bank_mapper #(.BUS_CONFLICT(1'b0), .KEY_KNOWN(1'b1), .PROT_KEY(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_mirror_v(cfg_mirror_v),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .prg_rdata(prg_rdata),
    .ppu_addr(ppu_addr), .ppu_dport_rd(ppu_dport_rd), .chr_rdata(chr_rdata),
    .chr_addr(a_addr), .chr_ce(a_ce), .chr_dout(a_dout), .chr_drive(a_drive),
    .ciram_a10(a_mir), .aux_out(a_aux), .wram_sel(a_wsel), .wram_addr(a_waddr)
  );

  chr_bank_mapper #(.BUS_CONFLICT(1'b1), .KEY_KNOWN(1'b0)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_mirror_v(cfg_mirror_v),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .prg_rdata(prg_rdata),
    .ppu_addr(ppu_addr), .ppu_dport_rd(ppu_dport_rd), .chr_rdata(chr_rdata),
    .chr_addr(b_addr), .chr_ce(b_ce), .chr_dout(b_dout), .chr_drive(b_drive),
    .ciram_a10(b_mir), .aux_out(b_aux), .wram_sel(b_wsel), .wram_addr(b_waddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input logic [7:0] p);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; prg_rdata = p; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    cfg_mode = 2'b00; ppu_addr = 14'h0123;
    #1;
    check("R1 addr", a_addr, 32'h0123);
    check("R1 aux", a_aux, 0);
    check("R1 addr b", b_addr, 32'h0123);
  endtask

  task automatic t_startup;
    cfg_mode = 2'b10; ppu_addr = 14'h0042;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      ppu_dport_rd = 1'b1;
      #1;
      check("R8 read gate", b_drive, (i >= 2) ? 1 : 0);
      check("R8 data", b_dout, (i >= 2) ? 32'hA5 : 32'h42);
    end
    @(negedge clk);
    ppu_dport_rd = 1'b0;
    cfg_mode = 2'b00;
  endtask

  task automatic t_decode;
    cpu_write(16'h7FFF, 8'hFF, 8'hFF);
    check("R2 low write bank", a_addr[16:13], 0);
    check("R2 low write aux", a_aux, 0);
    cpu_write(16'h8000, 8'h03, 8'hFF);
    check("R2 high write", a_addr[16:13], 3);
  endtask

  task automatic t_conflict;
    cfg_mode = 2'b00; ppu_addr = 14'h0555;
    cpu_write(16'hC000, 8'h3F, 8'h15);
    check("R3 plain", a_addr, (32'h3 << 13) | 32'h0555);
    check("R3 anded", b_addr, (32'h1 << 13) | 32'h0555);
    check("R9 aux plain", a_aux, 3);
    check("R9 aux anded", b_aux, 1);
  endtask

  task automatic t_normal;
    cfg_mode = 2'b00; ppu_addr = 14'h1ABC;
    cpu_write(16'hFFFF, 8'h0E, 8'hFF);
    #1;
    check("R4 bank", a_addr, (32'h2 << 13) | 32'h1ABC);
    check("R7 drive", a_drive, 1);
    check("R7 data", a_dout, 32'hA5);
  endtask

  task automatic t_oversize;
    cfg_mode = 2'b01; ppu_addr = 14'h1ABC;
    cpu_write(16'h9000, 8'h0B, 8'hFF);
    check("R5 bank", a_addr, (32'hB << 13) | 32'h1ABC);
    cpu_write(16'h9000, 8'h0B, 8'h0E);
    check("R5 anded", b_addr, (32'hA << 13) | 32'h1ABC);
  endtask

  task automatic t_protect;
    cfg_mode = 2'b10; ppu_addr = 14'h0077;
    cpu_write(16'h8000, 8'h02, 8'hFF);
    check("R6 key match", a_drive, 1);
    check("R6 bank zero", a_addr, 32'h0077);
    check("R7 rom data", a_dout, 32'hA5);
    cpu_write(16'h8000, 8'h01, 8'hFF);
    check("R6 key miss", a_drive, 0);
    check("R7 open bus", a_dout, 32'h77);
    check("R7 ce off", a_ce, 0);
    check("R8 after startup", b_drive, 1);
    cpu_write(16'h8000, 8'h36, 8'hFF);
    check("R6 upper bits ignored", a_drive, 1);
    check("R9 aux no addr effect", a_addr, 32'h0077);
    cfg_mode = 2'b00;
  endtask

  task automatic t_window;
    cfg_mode = 2'b00; ppu_addr = 14'h2C5A;
    #1;
    check("R12 drive", a_drive, 0);
    check("R12 ce", a_ce, 0);
    check("R12 data", a_dout, 32'h5A);
  endtask

  task automatic t_mirror;
    cfg_mirror_v = 1'b0; ppu_addr = 14'h2400;
    #1; check("R10 horiz 2400", a_mir, 1);
    ppu_addr = 14'h2800;
    #1; check("R10 horiz 2800", a_mir, 0);
    cfg_mirror_v = 1'b1;
    #1; check("R10 vert 2800", a_mir, 1);
    ppu_addr = 14'h2400;
    #1; check("R10 vert 2400", a_mir, 0);
    cpu_write(16'h8000, 8'hFF, 8'hFF);
    check("R10 write no effect", a_mir, 0);
  endtask

  task automatic t_wram;
    cpu_addr = 16'h6ABC; #1;
    check("R11 sel low", a_wsel, 1);
    check("R11 addr", a_waddr, 32'h2BC);
    cpu_addr = 16'h7ABC; #1;
    check("R11 mirror", a_waddr, 32'h2BC);
    check("R11 sel high", a_wsel, 1);
    cpu_addr = 16'h8000; #1;
    check("R11 rom area", a_wsel, 0);
    cpu_addr = 16'h5FFF; #1;
    check("R11 below", a_wsel, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_startup();
    t_decode();
    t_conflict();
    t_normal();
    t_oversize();
    t_protect();
    t_window();
    t_mirror();
    t_wram();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule